// File: doc/BRIEF.md
# Converter Module Power-Up Sequencer

This block brings a dual-channel data converter module from a cold state to a configured, running state after a single start request. It owns four control lines toward the module: one driver-enable line per channel (a low level keeps that channel's driver powered down), an enable for the low-voltage digital supply, and the parallel/serial interface select. On start it forces all four low. It then waits a long supply-settling interval and turns on the low-voltage supply. After a second, shorter settling interval it powers up both channel drivers.

With the analog side up, the sequencer asks an external serial register master to perform a sequence of register writes. The first write is a software reset. The writes after it replay a fixed list of configuration address/data pairs, in ascending index order. Each write is offered on a request/acknowledge port. A refused write (nack), or a write that gets no answer within a bounded number of cycles, stops the sequence in an error state with the control lines frozen. When every write has been acknowledged, the block raises done.

All intervals are parameters counted in clock cycles. The nominal values are 1000 ms and 500 ms at 100 MHz. A divider-based tick keeps the interval counters narrow, and a simulation can scale the intervals down.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, and in the cycle after a start accepted from the idle, done or error state, `chan_on_o`, `lv_sup_en_o` and `bus_sel_o` are all 0 and `done_o` and `err_o` are 0.
- R2: `lv_sup_en_o` rises exactly 2 + WAIT_SUP_TICKS*TICK_DIV cycles after the clock edge that accepts start. `chan_on_o` is still 0 at that point.
- R3: Both bits of `chan_on_o` rise together, exactly 2 + WAIT_DRV_TICKS*TICK_DIV cycles after `lv_sup_en_o` rose. `lv_sup_en_o` stays 1.
- R4: `wr_req_o` first rises one cycle after `chan_on_o` becomes 2'b11. The first write carries RST_ADDR/RST_DATA. A request is never made while `chan_on_o` is not 2'b11.
- R5: After the reset write is acknowledged, configuration entry k (bits [k*AW +: AW] of CFG_ADDR and [k*DW +: DW] of CFG_DATA) is written for k = 0 upward. Address and data stay stable while a request is pending, and the next write is presented in the cycle after an ack.
- R6: `done_o` rises in the cycle after the last configuration write is acknowledged, with `wr_req_o` low. `done_o` and `err_o` are never both 1.
- R7: A nack on a pending write raises `err_o` in the next cycle and drops `wr_req_o`. While in error, `chan_on_o` and `lv_sup_en_o` hold their values until a new start.
- R8: If a write sees neither ack nor nack, the request stays up for exactly ACK_TMO cycles and `err_o` rises in the following cycle.
- R9: A start pulse while a sequence is in progress is ignored, and the timing of the sequence is unchanged.
- R10: `bus_sel_o` stays 0 (parallel/serial select held low) throughout the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| chan_on_o | output | 2 | Per-channel driver enable (0 = channel powered down) |
| lv_sup_en_o | output | 1 | Low-voltage digital supply enable |
| bus_sel_o | output | 1 | Parallel/serial interface select, held low |
| wr_req_o | output | 1 | Register write request, held until ack or nack |
| wr_addr_o | output | AW | Register address of the pending write |
| wr_data_o | output | DW | Register data of the pending write |
| wr_ack_i | input | 1 | Write accepted by the serial master |
| wr_nack_i | input | 1 | Write refused by the serial master |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sequence aborted on nack or timeout |

## Verification
Timing is counted from the edge that accepts start. The supply enable is due 2 + WAIT_SUP_TICKS*TICK_DIV cycles later, the channel enables 2 + WAIT_DRV_TICKS*TICK_DIV cycles after that, the first request one cycle after the channel enables, and done or err one cycle after the final ack or nack. The bench keeps a free-running edge counter, samples every output at the falling edge, and compares the exact counter differences against these formulas. The counter is never used as a lower or upper bound. For the timeout, the bench counts the falling edges on which the silent request is high and expects exactly ACK_TMO, with err visible on the next one.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOW,
      ST_WAIT_SUP,
      ST_SUP_ON,
      ST_WAIT_DRV,
      ST_DRV_ON,
      ST_WRITE,
      ST_DONE,
      ST_ERR
   } seq_state_e;

   localparam int NUM_CHAN = 2;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
   parameter int DIV = 4,
   parameter int CW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [CW-1:0] limit_i,
   output logic          expired_o
);
   localparam int DVW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [DVW-1:0] DIV_LAST = DVW'(DIV - 1);

   logic [DVW-1:0] div_q;
   logic [CW-1:0]  tick_q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("pwrup_tick_timer: DIV must be at least 2");
      end
   endgenerate

   assign expired_o = (tick_q == limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         tick_q <= '0;
      end else if (!run_i) begin
         div_q  <= '0;
         tick_q <= '0;
      end else if (!expired_o) begin
         if (div_q == DIV_LAST) begin
            div_q  <= '0;
            tick_q <= tick_q + CW'(1);
         end else begin
            div_q <= div_q + DVW'(1);
         end
      end
   end

endmodule

// File: rtl/pwrup_wr_port.sv
module pwrup_wr_port #(
   parameter int TMO = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic ack_i,
   input  logic nack_i,
   output logic ok_o,
   output logic fail_o
);
   localparam int TW = $clog2(TMO);
   localparam logic [TW-1:0] TMO_LAST = TW'(TMO - 1);

   logic [TW-1:0] wait_q;
   logic          timed_out;

   generate
      if (TMO < 2) begin : g_bad_tmo
         $error("pwrup_wr_port: TMO must be at least 2");
      end
   endgenerate

   assign timed_out = (wait_q == TMO_LAST) && !ack_i;
   assign ok_o      = act_i && ack_i && !nack_i;
   assign fail_o    = act_i && (nack_i || timed_out);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q <= '0;
      end else if (!act_i || ack_i || nack_i) begin
         wait_q <= '0;
      end else if (wait_q != TMO_LAST) begin
         wait_q <= wait_q + TW'(1);
      end
   end

endmodule

// File: rtl/pwrup_cfg_rom.sv
module pwrup_cfg_rom #(
   parameter int                     AW       = 8,
   parameter int                     DW       = 8,
   parameter int                     N_CFG    = 4,
   parameter int                     IW       = 3,
   parameter logic [AW-1:0]          RST_ADDR = '0,
   parameter logic [DW-1:0]          RST_DATA = '0,
   parameter logic [N_CFG*AW-1:0]    CFG_ADDR = '0,
   parameter logic [N_CFG*DW-1:0]    CFG_DATA = '0
) (
   input  logic [IW-1:0] idx_i,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o,
   output logic          last_o
);
   localparam int NENT = N_CFG + 1;

   logic [AW-1:0] tab_addr [NENT];
   logic [DW-1:0] tab_data [NENT];

   assign tab_addr[0] = RST_ADDR;
   assign tab_data[0] = RST_DATA;

   generate
      for (genvar g = 0; g < N_CFG; g++) begin : g_ent
         assign tab_addr[g+1] = CFG_ADDR[g*AW +: AW];
         assign tab_data[g+1] = CFG_DATA[g*DW +: DW];
      end
   endgenerate

   always_comb begin
      addr_o = '0;
      data_o = '0;
      for (int k = 0; k < NENT; k++) begin
         if (idx_i == IW'(k)) begin
            addr_o = tab_addr[k];
            data_o = tab_data[k];
         end
      end
   end

   assign last_o = (idx_i == IW'(N_CFG));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
   import pwrup_pkg::*;
#(
   parameter int                  AW             = 8,
   parameter int                  DW             = 8,
   parameter int                  N_CFG          = 4,
   parameter logic [AW-1:0]       RST_ADDR       = '0,
   parameter logic [DW-1:0]       RST_DATA       = 8'h80,
   parameter logic [N_CFG*AW-1:0] CFG_ADDR       = {8'h14, 8'h0B, 8'h03, 8'h01},
   parameter logic [N_CFG*DW-1:0] CFG_DATA       = {8'h00, 8'h07, 8'h10, 8'h00},
   parameter int                  TICK_DIV       = 100000,
   parameter int                  WAIT_SUP_TICKS = 1000,
   parameter int                  WAIT_DRV_TICKS = 500,
   parameter int                  ACK_TMO        = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   output logic [NUM_CHAN-1:0] chan_on_o,
   output logic                lv_sup_en_o,
   output logic                bus_sel_o,
   output logic                wr_req_o,
   output logic [AW-1:0]       wr_addr_o,
   output logic [DW-1:0]       wr_data_o,
   input  logic                wr_ack_i,
   input  logic                wr_nack_i,
   output logic                done_o,
   output logic                err_o
);
   localparam int WMAX = max_int(WAIT_SUP_TICKS, WAIT_DRV_TICKS);
   localparam int CW   = $clog2(WMAX + 1);
   localparam int IW   = $clog2(N_CFG + 1);

   generate
      if (N_CFG < 1) begin : g_bad_ncfg
         $error("pwrup_seq: N_CFG must be at least 1");
      end
      if (WAIT_SUP_TICKS < 1 || WAIT_DRV_TICKS < 1) begin : g_bad_wait
         $error("pwrup_seq: wait intervals must be at least one tick");
      end
   endgenerate

   seq_state_e          state_q;
   logic [IW-1:0]       idx_q;
   logic                lv_q;
   logic [NUM_CHAN-1:0] drv_q;

   logic                tmr_run;
   logic [CW-1:0]       tmr_limit;
   logic                tmr_exp;
   logic                wr_ok;
   logic                wr_fail;
   logic                list_last;
   logic                idle_like;

   assign tmr_run   = (state_q == ST_WAIT_SUP) || (state_q == ST_WAIT_DRV);
   assign tmr_limit = (state_q == ST_WAIT_DRV) ? CW'(WAIT_DRV_TICKS) : CW'(WAIT_SUP_TICKS);
   assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERR);

   pwrup_tick_timer #(
      .DIV (TICK_DIV),
      .CW  (CW)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (tmr_run),
      .limit_i   (tmr_limit),
      .expired_o (tmr_exp)
   );

   pwrup_wr_port #(
      .TMO (ACK_TMO)
   ) u_wport (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (wr_req_o),
      .ack_i  (wr_ack_i),
      .nack_i (wr_nack_i),
      .ok_o   (wr_ok),
      .fail_o (wr_fail)
   );

   pwrup_cfg_rom #(
      .AW       (AW),
      .DW       (DW),
      .N_CFG    (N_CFG),
      .IW       (IW),
      .RST_ADDR (RST_ADDR),
      .RST_DATA (RST_DATA),
      .CFG_ADDR (CFG_ADDR),
      .CFG_DATA (CFG_DATA)
   ) u_rom (
      .idx_i  (idx_q),
      .addr_o (wr_addr_o),
      .data_o (wr_data_o),
      .last_o (list_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         lv_q    <= 1'b0;
         drv_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE, ST_DONE, ST_ERR: begin
               if (start_i) begin
                  state_q <= ST_LOW;
                  idx_q   <= '0;
                  lv_q    <= 1'b0;
                  drv_q   <= '0;
               end
            end
            ST_LOW:      state_q <= ST_WAIT_SUP;
            ST_WAIT_SUP: begin
               if (tmr_exp) begin
                  state_q <= ST_SUP_ON;
                  lv_q    <= 1'b1;
               end
            end
            ST_SUP_ON:   state_q <= ST_WAIT_DRV;
            ST_WAIT_DRV: begin
               if (tmr_exp) begin
                  state_q <= ST_DRV_ON;
                  drv_q   <= '1;
               end
            end
            ST_DRV_ON:   state_q <= ST_WRITE;
            ST_WRITE: begin
               if (wr_fail) begin
                  state_q <= ST_ERR;
               end else if (wr_ok) begin
                  if (list_last) state_q <= ST_DONE;
                  else           idx_q   <= idx_q + IW'(1);
               end
            end
            default:     state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
         assign chan_on_o[c] = drv_q[c];
      end
   endgenerate

   assign lv_sup_en_o = lv_q;
   assign bus_sel_o   = 1'b0;
   assign wr_req_o    = (state_q == ST_WRITE);
   assign done_o      = (state_q == ST_DONE);
   assign err_o       = (state_q == ST_ERR);

   logic unused_idle;
   assign unused_idle = idle_like;

endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic [1:0]    chan_on_o,
   input logic          lv_sup_en_o,
   input logic          wr_req_o,
   input logic [AW-1:0] wr_addr_o,
   input logic [DW-1:0] wr_data_o,
   input logic          wr_ack_i,
   input logic          wr_nack_i,
   input logic          done_o,
   input logic          err_o
);

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && (done_o || err_o) |=> (chan_on_o == 2'b00) && !lv_sup_en_o && !done_o && !err_o); // R1

   AST_DRV_AFTER_SUP: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_on_o != 2'b00) |-> lv_sup_en_o && (chan_on_o == 2'b11)); // R3

   AST_REQ_NEEDS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> (chan_on_o == 2'b11)); // R4

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && !wr_ack_i && !wr_nack_i |=>
         err_o || (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R5

   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R6

   AST_NACK_TO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && wr_nack_i |=> err_o && !wr_req_o); // R7

   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !start_i |=> err_o && $stable(chan_on_o) && $stable(lv_sup_en_o)); // R7

endmodule

bind pwrup_seq pwrup_seq_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .chan_on_o   (chan_on_o),
   .lv_sup_en_o (lv_sup_en_o),
   .wr_req_o    (wr_req_o),
   .wr_addr_o   (wr_addr_o),
   .wr_data_o   (wr_data_o),
   .wr_ack_i    (wr_ack_i),
   .wr_nack_i   (wr_nack_i),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;
   localparam int AW    = 8;
   localparam int DW    = 8;
   localparam int NCFG  = 3;
   localparam int DIV   = 4;
   localparam int W1    = 10;
   localparam int W2    = 5;
   localparam int TMO   = 16;
   localparam int LAT   = 2;
   localparam logic [AW-1:0] RA = 8'h00;
   localparam logic [DW-1:0] RD = 8'h81;
   localparam logic [NCFG*AW-1:0] CA = {8'h07, 8'h05, 8'h02};
   localparam logic [NCFG*DW-1:0] CD = {8'hA5, 8'h3C, 8'h10};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ack = 1'b0;
   logic nack = 1'b0;
   logic [1:0] chan_on;
   logic lv, bsel, req, done, err;
   logic [AW-1:0] waddr;
   logic [DW-1:0] wdata;

   always #5 clk = ~clk;

   pwrup_seq #(
      .AW(AW), .DW(DW), .N_CFG(NCFG), .RST_ADDR(RA), .RST_DATA(RD),
      .CFG_ADDR(CA), .CFG_DATA(CD), .TICK_DIV(DIV),
      .WAIT_SUP_TICKS(W1), .WAIT_DRV_TICKS(W2), .ACK_TMO(TMO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chan_on_o(chan_on),
      .lv_sup_en_o(lv), .bus_sel_o(bsel), .wr_req_o(req), .wr_addr_o(waddr),
      .wr_data_o(wdata), .wr_ack_i(ack), .wr_nack_i(nack), .done_o(done), .err_o(err)
   );

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // scoreboard of expected writes {addr, data}
   logic [AW+DW-1:0] exp_q[$];
   int mode = 0;      // 0 ack all, 1 nack write tgt, 2 ignore write tgt
   int tgt = 0;
   int wcnt = 0;
   int wait_c = 0;
   int hi = 0;
   int resp_cyc = 0;

   task automatic push_expected();
      exp_q.delete();
      exp_q.push_back({RA, RD});
      for (int i = 0; i < NCFG; i++)
         exp_q.push_back({CA[i*AW +: AW], CD[i*DW +: DW]});
   endtask

   // monitor / responder: pops expected writes as the design presents them
   always @(negedge clk) begin
      if (ack || nack) begin
         ack = 1'b0;
         nack = 1'b0;
      end
      if (req) begin
         hi++;
         if (!(mode == 2 && wcnt == tgt)) begin
            if (wait_c == LAT) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R5 unexpected write", int'(waddr), -1);
               end else begin
                  logic [AW+DW-1:0] e;
                  e = exp_q.pop_front();
                  if (wcnt == 0)
                     check({waddr, wdata} == e, "R4 reset write pair", int'({waddr, wdata}), int'(e));
                  else
                     check({waddr, wdata} == e, "R5 config write pair", int'({waddr, wdata}), int'(e));
               end
               if (mode == 1 && wcnt == tgt) nack = 1'b1;
               else ack = 1'b1;
               wcnt++;
               resp_cyc = cyc;
               wait_c = 0;
               hi = 0;
            end else begin
               wait_c++;
            end
         end
      end
   end

   task automatic start_pulse(output int s);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      s = cyc;
   endtask

   task automatic summary_and_end();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 20000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
         summary_and_end();
      end
   end

   // runs one sequence to done and checks the timing of every step
   task automatic full_run(input bit mid_start);
      int s, lvc, chc, rqc;
      mode = 0; wcnt = 0; wait_c = 0; hi = 0;
      push_expected();
      start_pulse(s);
      check(chan_on == 2'b00 && !lv && !done && !err, "R1 start clears outputs",
            int'({chan_on, lv, done, err}), 0);
      if (mid_start) begin
         repeat (6) @(negedge clk);
         start = 1'b1;  // R9: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (!lv) @(negedge clk);
      lvc = cyc;
      check(lvc - s == 2 + W1 * DIV, mid_start ? "R9 supply timing after busy start" : "R2 supply timing",
            lvc - s, 2 + W1 * DIV);
      check(chan_on == 2'b00, "R2 channels off at supply rise", int'(chan_on), 0);
      while (chan_on == 2'b00) @(negedge clk);
      chc = cyc;
      check(chan_on == 2'b11, "R3 both channels together", int'(chan_on), 3);
      check(chc - lvc == 2 + W2 * DIV, "R3 driver timing", chc - lvc, 2 + W2 * DIV);
      check(lv, "R3 supply stays on", int'(lv), 1);
      while (!req) @(negedge clk);
      rqc = cyc;
      check(rqc - chc == 1, "R4 first request timing", rqc - chc, 1);
      while (!done && !err) begin
         check(!bsel, "R10 select held low", int'(bsel), 0);
         @(negedge clk);
      end
      check(done && !err, "R6 done raised", int'({done, err}), 2);
      check(cyc - resp_cyc == 1, "R6 done one cycle after last ack", cyc - resp_cyc, 1);
      check(!req, "R6 request low at done", int'(req), 0);
      check(wcnt == NCFG + 1 && exp_q.size() == 0, "R5 all writes in order",
            wcnt, NCFG + 1);
   endtask

   initial begin
      int s;
      repeat (4) @(negedge clk);
      check(chan_on == 2'b00 && !lv && !bsel && !done && !err && !req, "R1 reset state",
            int'({chan_on, lv, bsel, done, err, req}), 0);
      rst_n = 1'b1;

      full_run(1'b0);
      full_run(1'b1);

      // nack on the second configuration write
      mode = 1; tgt = 2; wcnt = 0; wait_c = 0; hi = 0;
      push_expected();
      start_pulse(s);
      check(!done && chan_on == 2'b00, "R1 restart after done", int'({done, chan_on}), 0);
      while (!err) @(negedge clk);
      check(cyc - resp_cyc == 1, "R7 err one cycle after nack", cyc - resp_cyc, 1);
      check(!req && !done, "R7 request dropped", int'({req, done}), 0);
      check(chan_on == 2'b11 && lv, "R7 outputs held", int'({chan_on, lv}), 7);
      repeat (10) @(negedge clk);
      check(err && chan_on == 2'b11 && lv, "R7 error state persists",
            int'({err, chan_on, lv}), 15);

      // silent responder on the reset write -> timeout
      mode = 2; tgt = 0; wcnt = 0; wait_c = 0; hi = 0;
      push_expected();
      start_pulse(s);
      check(!err && chan_on == 2'b00 && !lv, "R1 restart after error",
            int'({err, chan_on, lv}), 0);
      while (!err) @(negedge clk);
      check(hi == TMO, "R8 request held for timeout", hi, TMO);
      check(!req && chan_on == 2'b11 && lv, "R8 error with outputs held",
            int'({req, chan_on, lv}), 7);

      summary_and_end();
   end

endmodule